// File: doc/BRIEF.md
# Cycle-by-Cycle Overcurrent Limiter with Overload Shutdown

This block protects one channel of a PWM power stage. It watches a PWM reference and the flag from an overcurrent comparator, both already in the clock domain. When the flag is raised, the channel's drive enable is removed for the rest of the current PWM period. The next rising edge of the PWM reference opens the drive again.

A leaky event counter keeps track of how often periods end with a trip. It steps up once for every `M_UP` periods that saw overcurrent and steps down once for every `N_DN` trip-free periods. When it reaches `THRESH` (1000 by default), the channel is shut down. The shutdown is latched and stays in place until either reset clears it. The gated drive enable is registered, so it follows `pwm_in` with a latency of one clock.

A PWM period runs from one rising edge of `pwm_in` to the next. After any reset, the drive stays off until the first rising edge, and that first partial period is never counted.

Top module: `cbc_overload_guard`

## Requirements
- R1: With no trip pending and no shutdown, after the first PWM rising edge since reset, `drive_en` equals `pwm_in` delayed by one clock.
- R2: If `oc_flag` is high in a clock cycle, `drive_en` is low in the following cycle and stays low until the next PWM rising edge.
- R3: On the clock cycle of a PWM rising edge (`pwm_in` high where it was low one clock earlier) with `oc_flag` low, `drive_en` goes high in the next cycle, even if the previous period tripped.
- R4: Any number of `oc_flag` pulses within one PWM period count as a single overcurrent period.
- R5: At each PWM rising edge that closes an overcurrent period, an up-prescaler advances. Every `M_UP`-th such period increments `ovl_count` by exactly 1 and clears both prescalers. `ovl_count` changes only at the clock after a PWM rising edge, or after a synchronous reset.
- R6: At each PWM rising edge that closes a trip-free period, a down-prescaler advances while `ovl_count` is nonzero. Every `N_DN`-th such period decrements `ovl_count` by 1 and clears both prescalers. At zero the count holds at 0.
- R7: In the clock after `ovl_count` reaches `THRESH`, `shutdown` is high. `ovl_count` then holds at `THRESH` and never exceeds it.
- R8: Once set, `shutdown` stays high, and `drive_en` stays low whatever `pwm_in` and `oc_flag` do, until `srst` or `rst_n` clears it.
- R9: A high `srst` at a clock edge clears `ovl_count`, `shutdown` and both prescalers, and forces `drive_en` low in the next cycle. The drive opens again only after the next PWM rising edge.
- R10: While `rst_n` is low, `ovl_count` is 0, `shutdown` is 0 and `drive_en` is 0. `rst_n` takes effect asynchronously and is released through two flops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| srst | input | 1 | Synchronous clear of the count, the shutdown latch and the prescalers |
| pwm_in | input | 1 | PWM reference, synchronous to clk |
| oc_flag | input | 1 | Overcurrent comparator flag, synchronous to clk |
| drive_en | output | 1 | Gated drive enable, registered |
| shutdown | output | 1 | Latched overload shutdown |
| ovl_count | output | $clog2(THRESH+1) | Overload counter value |

## Verification
The overlaps that matter here fall in the same clock as a PWM rising edge:
- the edge closes the old period and updates the counter, while a fresh `oc_flag` must already blank the new period;
- a synchronous reset that lands on that same edge must win over both the count update and the re-arming.

The bench provokes these by placing `oc_flag` and `srst` on the first clock of a period, in directed cases and in random mixes. It judges every cycle against a period-level model of the rules for drive, count and shutdown.

// File: rtl/cbc_pkg.sv
package cbc_pkg;

  // One closed PWM period, reported at the rising edge that ends it
  typedef struct packed {
    logic fire;     // an armed period has just ended
    logic had_oc;   // that period contained at least one trip
  } cbc_period_t;

  function automatic int unsigned cbc_width(input int unsigned v);
    return (v > 1) ? $clog2(v) : 1;
  endfunction

endpackage

// File: rtl/cbc_rst_sync.sv
module cbc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic stage_q;
  logic hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 1'b0;
      hold_q  <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      hold_q  <= stage_q;
    end
  end

  assign rst_sync_n = hold_q;

endmodule

// File: rtl/cbc_period_track.sv
module cbc_period_track
  import cbc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_ni,
  input  logic        srst,
  input  logic        pwm_in,
  input  logic        oc_flag,
  output cbc_period_t evt,
  output logic        armed_nx,
  output logic        blank_nx
);

  logic pwm_q;
  logic armed_q, armed_d;
  logic trip_q, trip_d;
  logic rise;
  logic trip_en;

  assign rise = pwm_in & ~pwm_q;

  always_comb begin
    armed_d    = armed_q;
    trip_d     = trip_q | oc_flag;
    evt.fire   = rise & armed_q & ~srst;
    evt.had_oc = trip_q;
    if (srst) begin
      armed_d = 1'b0;
      trip_d  = 1'b0;
    end else if (rise) begin
      armed_d = 1'b1;
      trip_d  = oc_flag;
    end
  end

  assign trip_en  = srst | rise | oc_flag;
  assign armed_nx = armed_d;
  assign blank_nx = trip_d;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      pwm_q   <= 1'b0;
      armed_q <= 1'b0;
      trip_q  <= 1'b0;
    end else begin
      pwm_q <= pwm_in;
      if (srst | rise) armed_q <= armed_d;
      if (trip_en)     trip_q  <= trip_d;
    end
  end

endmodule

// File: rtl/cbc_overload_cnt.sv
module cbc_overload_cnt
  import cbc_pkg::*;
#(
  parameter int unsigned THRESH = 1000,
  parameter int unsigned M_UP   = 1,
  parameter int unsigned N_DN   = 1,
  localparam int unsigned CNT_W = $clog2(THRESH + 1)
)(
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             srst,
  input  cbc_period_t      evt,
  output logic [CNT_W-1:0] cnt_q,
  output logic             shut_q,
  output logic             shut_nx
);

  localparam int unsigned UP_W = cbc_width(M_UP);
  localparam int unsigned DN_W = cbc_width(N_DN);
  localparam logic [UP_W-1:0]  UP_LAST = UP_W'(M_UP - 1);
  localparam logic [DN_W-1:0]  DN_LAST = DN_W'(N_DN - 1);
  localparam logic [CNT_W-1:0] TH_V    = CNT_W'(THRESH);

  logic [CNT_W-1:0] cnt_d;
  logic [UP_W-1:0]  up_q, up_d;
  logic [DN_W-1:0]  dn_q, dn_d;
  logic             shut_d;
  logic             cnt_en;

  always_comb begin
    cnt_d = cnt_q;
    up_d  = up_q;
    dn_d  = dn_q;
    if (srst) begin
      cnt_d = '0;
      up_d  = '0;
      dn_d  = '0;
    end else if (evt.fire && !shut_q) begin
      if (evt.had_oc) begin
        if (up_q == UP_LAST) begin
          cnt_d = cnt_q + CNT_W'(1);
          up_d  = '0;
          dn_d  = '0;
        end else begin
          up_d = up_q + UP_W'(1);
        end
      end else if (cnt_q != '0) begin
        if (dn_q == DN_LAST) begin
          cnt_d = cnt_q - CNT_W'(1);
          up_d  = '0;
          dn_d  = '0;
        end else begin
          dn_d = dn_q + DN_W'(1);
        end
      end
    end
    shut_d = srst ? 1'b0 : (shut_q | (cnt_d == TH_V));
  end

  assign cnt_en  = srst | evt.fire;
  assign shut_nx = shut_d;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      up_q   <= '0;
      dn_q   <= '0;
      shut_q <= 1'b0;
    end else if (cnt_en) begin
      cnt_q  <= cnt_d;
      up_q   <= up_d;
      dn_q   <= dn_d;
      shut_q <= shut_d;
    end
  end

endmodule

// File: rtl/cbc_drive_gate.sv
module cbc_drive_gate (
  input  logic clk,
  input  logic rst_ni,
  input  logic pwm_in,
  input  logic armed_nx,
  input  logic blank_nx,
  input  logic shut_nx,
  output logic drive_q
);

  logic drive_d;

  always_comb begin
    drive_d = pwm_in & armed_nx & ~blank_nx & ~shut_nx;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) drive_q <= 1'b0;
    else         drive_q <= drive_d;
  end

endmodule

// File: rtl/cbc_overload_guard.sv
module cbc_overload_guard
  import cbc_pkg::*;
#(
  parameter int unsigned THRESH = 1000,
  parameter int unsigned M_UP   = 1,
  parameter int unsigned N_DN   = 1,
  localparam int unsigned CNT_W = $clog2(THRESH + 1)
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             srst,
  input  logic             pwm_in,
  input  logic             oc_flag,
  output logic             drive_en,
  output logic             shutdown,
  output logic [CNT_W-1:0] ovl_count
);

  logic        rst_ni;
  cbc_period_t evt;
  logic        armed_nx;
  logic        blank_nx;
  logic        shut_nx;

  cbc_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_ni)
  );

  cbc_period_track u_track (
    .clk      (clk),
    .rst_ni   (rst_ni),
    .srst     (srst),
    .pwm_in   (pwm_in),
    .oc_flag  (oc_flag),
    .evt      (evt),
    .armed_nx (armed_nx),
    .blank_nx (blank_nx)
  );

  cbc_overload_cnt #(
    .THRESH (THRESH),
    .M_UP   (M_UP),
    .N_DN   (N_DN)
  ) u_cnt (
    .clk     (clk),
    .rst_ni  (rst_ni),
    .srst    (srst),
    .evt     (evt),
    .cnt_q   (ovl_count),
    .shut_q  (shutdown),
    .shut_nx (shut_nx)
  );

  cbc_drive_gate u_gate (
    .clk      (clk),
    .rst_ni   (rst_ni),
    .pwm_in   (pwm_in),
    .armed_nx (armed_nx),
    .blank_nx (blank_nx),
    .shut_nx  (shut_nx),
    .drive_q  (drive_en)
  );

endmodule

// File: rtl/cbc_guard_checker.sv
module cbc_guard_checker #(
  parameter int unsigned THRESH = 1000,
  localparam int unsigned CNT_W = $clog2(THRESH + 1)
)(
  input logic             clk,
  input logic             rst_n,
  input logic             srst,
  input logic             pwm_in,
  input logic             oc_flag,
  input logic             drive_en,
  input logic             shutdown,
  input logic [CNT_W-1:0] ovl_count
);

  localparam logic [CNT_W-1:0] TH_V = CNT_W'(THRESH);

  assert_trip_blanks_R2: assert property (@(posedge clk) disable iff (!rst_n)
    oc_flag |=> !drive_en);

  assert_count_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !srst |=> (ovl_count == $past(ovl_count)) ||
              (ovl_count == $past(ovl_count) + CNT_W'(1)) ||
              (ovl_count + CNT_W'(1) == $past(ovl_count)));

  assert_count_at_edge_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((ovl_count != $past(ovl_count)) && !$past(srst)) |-> $past(pwm_in));

  assert_count_cap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ovl_count <= TH_V);

  assert_shut_at_thresh_R7: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown |-> (ovl_count == TH_V));

  assert_shut_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (shutdown && !srst) |=> shutdown);

  assert_shut_no_drive_R8: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown |-> !drive_en);

  assert_srst_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    srst |=> (ovl_count == '0) && !shutdown && !drive_en);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      assert_reset_state_R10: assert (!shutdown && !drive_en && ovl_count == '0);
    end
  end

endmodule

bind cbc_overload_guard cbc_guard_checker #(.THRESH(THRESH)) u_guard_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .srst      (srst),
  .pwm_in    (pwm_in),
  .oc_flag   (oc_flag),
  .drive_en  (drive_en),
  .shutdown  (shutdown),
  .ovl_count (ovl_count)
);

// File: tb/test_cbc_overload_guard.sv
`timescale 1ns/1ps
module test_cbc_overload_guard;

  localparam int TH = 6;
  localparam int MU = 2;
  localparam int ND = 3;
  localparam int CW = $clog2(TH + 1);

  logic clk = 1'b0;
  logic rst_n, srst, pwm_in, oc_flag;
  logic drive_en, shutdown;
  logic [CW-1:0] ovl_count;

  always #2 clk = ~clk;

  cbc_overload_guard #(.THRESH(TH), .M_UP(MU), .N_DN(ND)) i_cbc_overload_guard (
    .clk(clk), .rst_n(rst_n), .srst(srst), .pwm_in(pwm_in), .oc_flag(oc_flag),
    .drive_en(drive_en), .shutdown(shutdown), .ovl_count(ovl_count)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;
  string cur_tag = "R1";

  // period-level model of the requirements
  int m_cnt, m_up, m_dn;
  bit m_shut, m_armed, m_cyc, m_pwmq, m_drive;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic void close_period(input bit had_oc);
    if (m_shut) return;
    if (had_oc) begin
      m_up++;
      if (m_up == MU) begin m_cnt++; m_up = 0; m_dn = 0; end
    end else if (m_cnt > 0) begin
      m_dn++;
      if (m_dn == ND) begin m_cnt--; m_up = 0; m_dn = 0; end
    end
    if (m_cnt == TH) m_shut = 1;
  endfunction

  function automatic void model_step(input bit p, input bit o, input bit s);
    bit rise;
    rise = p & ~m_pwmq;
    if (s) begin
      m_cnt = 0; m_up = 0; m_dn = 0; m_shut = 0; m_armed = 0; m_cyc = 0;
    end else if (rise) begin
      if (m_armed) close_period(m_cyc);
      m_armed = 1;
      m_cyc = o;
    end else begin
      m_cyc = m_cyc | o;
    end
    m_pwmq = p;
    m_drive = p & m_armed & ~m_cyc & ~m_shut;
  endfunction

  // called at a falling edge: drive, take one rising edge, compare at next falling edge
  task automatic tick(input bit p, input bit o, input bit s);
    pwm_in = p; oc_flag = o; srst = s;
    @(posedge clk);
    model_step(p, o, s);
    @(negedge clk);
    chk(drive_en == m_drive, cur_tag, "drive_en", drive_en, m_drive);
    chk(int'(ovl_count) == m_cnt, "R5", "ovl_count", ovl_count, m_cnt);
    chk(shutdown == m_shut, "R7", "shutdown", shutdown, m_shut);
  endtask

  task automatic run_ticks(input int from, input int to, input int hi,
                           input logic [15:0] mask, input int sr_at);
    for (int i = from; i < to; i++) tick(i < hi, mask[i], i == sr_at);
  endtask

  task automatic period(input int len, input int hi, input logic [15:0] mask);
    run_ticks(0, len, hi, mask, -1);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int len, hi, prob, sr_at;
    logic [15:0] mask;
    void'($urandom(32'd24681));
    rst_n = 1'b0; srst = 1'b0; pwm_in = 1'b0; oc_flag = 1'b0;
    m_cnt = 0; m_up = 0; m_dn = 0; m_shut = 0; m_armed = 0; m_cyc = 0; m_pwmq = 0; m_drive = 0;
    repeat (3) @(negedge clk);
    // R10: reset state
    chk(ovl_count == '0, "R10", "reset count", ovl_count, 0);
    chk(!shutdown, "R10", "reset shutdown", shutdown, 0);
    chk(!drive_en, "R10", "reset drive", drive_en, 0);
    rst_n = 1'b1;
    repeat (3) tick(0, 0, 0);

    // first partial period only arms; then plain following (R1)
    cur_tag = "R1";
    period(8, 4, 16'h0000);
    period(8, 5, 16'h0000);
    period(6, 2, 16'h0000);

    // R2: single trip blanks the rest of the period
    cur_tag = "R2";
    run_ticks(0, 2, 5, 16'h0002, -1);
    chk(!drive_en, "R2", "drive after trip", drive_en, 0);
    run_ticks(2, 8, 5, 16'h0002, -1);

    // R3: clean period re-enables on the edge
    cur_tag = "R3";
    run_ticks(0, 1, 5, 16'h0000, -1);
    chk(drive_en, "R3", "drive after edge", drive_en, 1);
    run_ticks(1, 8, 5, 16'h0000, -1);

    // R4: three pulses in one period count once (with earlier trip -> count 1)
    cur_tag = "R4";
    period(8, 5, 16'h0015);
    run_ticks(0, 1, 4, 16'h0000, -1);
    chk(ovl_count == CW'(1), "R4", "count after multi-pulse", ovl_count, 1);
    run_ticks(1, 8, 4, 16'h0000, -1);

    // R6: three clean periods step down, then hold at zero
    cur_tag = "R6";
    period(8, 4, 16'h0000);
    period(8, 4, 16'h0000);
    run_ticks(0, 1, 4, 16'h0000, -1);
    chk(ovl_count == '0, "R6", "count after decay", ovl_count, 0);
    run_ticks(1, 8, 4, 16'h0000, -1);
    period(8, 4, 16'h0000);
    period(8, 4, 16'h0000);
    run_ticks(0, 1, 4, 16'h0000, -1);
    chk(ovl_count == '0, "R6", "count saturated", ovl_count, 0);
    run_ticks(1, 8, 4, 16'h0000, -1);

    // R5 / R7: trips on every first clock drive count to the threshold
    cur_tag = "R5";
    for (int k = 0; k < 13; k++) begin
      run_ticks(0, 1, 4, 16'h0001, -1);
      if (k == 10) begin
        chk(ovl_count == CW'(5), "R5", "count after 10 trips", ovl_count, 5);
        chk(!shutdown, "R5", "no shutdown yet", shutdown, 0);
      end
      if (k == 12) begin
        chk(shutdown, "R7", "shutdown at threshold", shutdown, 1);
        chk(ovl_count == CW'(TH), "R7", "count at threshold", ovl_count, TH);
      end
      run_ticks(1, 6, 4, 16'h0001, -1);
    end

    // R8: latched shutdown ignores clean PWM and further trips
    cur_tag = "R8";
    for (int k = 0; k < 5; k++) period(7, 5, (k == 2) ? 16'h0008 : 16'h0000);
    chk(shutdown, "R8", "shutdown held", shutdown, 1);
    chk(ovl_count == CW'(TH), "R8", "count held", ovl_count, TH);

    // R9: synchronous reset mid-period
    cur_tag = "R9";
    run_ticks(0, 2, 6, 16'h0000, 1);
    chk(!shutdown, "R9", "shutdown cleared", shutdown, 0);
    chk(ovl_count == '0, "R9", "count cleared", ovl_count, 0);
    chk(!drive_en, "R9", "drive held off", drive_en, 0);
    run_ticks(2, 8, 6, 16'h0000, -1);
    run_ticks(0, 1, 4, 16'h0000, -1);
    chk(drive_en, "R9", "drive back after edge", drive_en, 1);
    run_ticks(1, 8, 4, 16'h0000, -1);

    // srst and trip on the very edge clock
    run_ticks(0, 8, 4, 16'h0001, 0);

    // random mix
    cur_tag = "R3";
    for (int p = 0; p < 500; p++) begin
      len = 4 + int'($urandom % 9);
      hi = 1 + int'($urandom % (len - 1));
      prob = ((p / 60) % 2 == 1) ? 60 : 8;
      mask = '0;
      for (int i = 0; i < len; i++) mask[i] = (($urandom % 100) < prob);
      sr_at = (($urandom % 40) == 0) ? int'($urandom % len) : -1;
      run_ticks(0, len, hi, mask, sr_at);
    end

    finish_run();
  end

endmodule